// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog counter that software must service periodically through a small word-wide register bus. To service the watchdog, software writes a first key word to one service register and then a second key word to another. Any service write that breaks this order or carries a wrong value is treated as a fault. When the counter expires, when the key sequence is broken, when software requests a soft reset, or when the user-reset input fires, the block raises a one-cycle reset request. It also records a 3-bit code for the cause, and software can read that code back after the system restarts.

Counting advances only on cycles where the tick-enable input is high. Configuration writes go into a pending copy. The counter only uses the pending enable and delay after a valid service, so both starting and stopping the watchdog require servicing it. Each reset request also sends the block back to its after-hard-reset state. The one exception is the cause code: it survives until the next reset request or until the hard-reset input is asserted.

Top module: `keyed_watchdog`

## Requirements
- R1: Word registers are decoded from `addr` bits 3:2, and any nonzero bit outside 3:2 selects nothing. Index 0 is soft reset, 1 is configuration, 2 is service A, and 3 is service B. Reading configuration returns the pending enable in bit 31 and the pending delay in bits 4:0, with all other bits zero. Reading service A returns the cause code in bits 2:0. The other two registers read as zero.
- R2: A valid service is 0xABCD1234 written to service A followed by 0x4321DCBA written to service B. Writes to configuration or soft reset between the two key writes do not break the sequence. A valid service clears the count and copies the pending enable and delay into the active configuration, without raising a request.
- R3: While the watchdog is active with delay d, `rst_req` rises after the 2^(d+1)-th tick-enabled cycle since the last valid service, and the cause becomes 1. Cycles with `tick_en` low do not count.
- R4: A configuration write by itself changes nothing in the counting. Setting enable without a service does not start the counter, and clearing enable without a service does not stop it.
- R5: Each of the following is a bad tickle, whether or not the watchdog is active, and raises `rst_req` with cause 2:
  - while idle, a non-first-key write to service A;
  - while idle, any write to service B;
  - while waiting for the second key, any write to service A;
  - while waiting for the second key, a wrong value written to service B.
- R6: A soft-reset write with bit 0 set raises `rst_req` with cause 3. A soft-reset write with bit 0 clear has no effect.
- R7: `user_rst` high at a clock edge raises `rst_req` with cause 4.
- R8: If several causes occur at the same edge, the recorded code follows the priority user (4) over soft (3) over bad tickle (2) over timeout (1).
- R9: `rst_req` is high for exactly the cycle after each triggering edge. Each request disables the active configuration, clears the pending configuration and the count, and abandons a half-done key sequence.
- R10: The cause code holds until the next request. While `rst_n` is low, the cause is 0 and `rst_req` is low.
- R11: After a hard reset the watchdog is inactive, and ticks raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hard reset; clears everything including the cause |
| tick_en | input | 1 | Counter advance enable, one watchdog tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | DATA_W | Write data |
| user_rst | input | 1 | User reset request |
| rdata | output | DATA_W | Read data for `addr` (combinational by default) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
On every cycle, the assertions check the following:
- the count stays within the active period, and a valid service leaves it at zero;
- a bad tickle leaves the sequencer idle;
- the cause code changes only together with a reset request, and a request never carries the hard-reset code;
- a configuration write lands in the pending fields.

Only the bench's scenarios can show the rest. These are the exact tick on which a timeout fires for each delay, that configuration changes wait for a service, the four bad-tickle shapes, the priority between coincident causes, and that the block returns to an idle state after each request.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   typedef enum logic [2:0] {
      CAUSE_HARD = 3'd0,
      CAUSE_TMO  = 3'd1,
      CAUSE_BAD  = 3'd2,
      CAUSE_SOFT = 3'd3,
      CAUSE_USER = 3'd4
   } cause_e;

   localparam logic [1:0] IDX_SOFT  = 2'd0;
   localparam logic [1:0] IDX_CFG   = 2'd1;
   localparam logic [1:0] IDX_SVC_A = 2'd2;
   localparam logic [1:0] IDX_SVC_B = 2'd3;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
   import kwd_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int DLY_W     = 5,
   parameter int EN_BIT    = 31,
   parameter bit READ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              w_en_bit,
   input  logic [DLY_W-1:0]  w_dly,
   input  logic              w_soft_bit,
   input  logic              flush,
   input  logic [2:0]        cause,
   output logic              wr_svc_a,
   output logic              wr_svc_b,
   output logic              soft_hit,
   output logic              pend_en,
   output logic [DLY_W-1:0]  pend_dly,
   output logic [DATA_W-1:0] rdata
);
   logic              in_range;
   logic [1:0]        idx;
   logic              wr_cfg;
   logic [DATA_W-1:0] rd_mux;

   assign idx = addr[3:2];

   generate
      if (ADDR_W > 4) begin : g_wide_addr
         assign in_range = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
      end else begin : g_narrow_addr
         assign in_range = (addr[1:0] == 2'b00);
      end
   endgenerate

   assign wr_cfg   = wr_en && in_range && (idx == IDX_CFG);
   assign wr_svc_a = wr_en && in_range && (idx == IDX_SVC_A);
   assign wr_svc_b = wr_en && in_range && (idx == IDX_SVC_B);
   assign soft_hit = wr_en && in_range && (idx == IDX_SOFT) && w_soft_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_en  <= 1'b0;
         pend_dly <= '0;
      end else if (flush) begin
         pend_en  <= 1'b0;
         pend_dly <= '0;
      end else if (wr_cfg) begin
         pend_en  <= w_en_bit;
         pend_dly <= w_dly;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (in_range) begin
         unique case (idx)
            IDX_CFG: begin
               rd_mux[EN_BIT]      = pend_en;
               rd_mux[DLY_W-1:0]   = pend_dly;
            end
            IDX_SVC_A: rd_mux[2:0] = cause;
            default:   rd_mux      = '0;
         endcase
      end
   end

   generate
      if (READ_FLOP) begin : g_read_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_mux;
         end
      end else begin : g_read_comb
         assign rdata = rd_mux;
      end
   endgenerate

   // R1
   cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_cfg) && !$past(flush) |->
         (pend_en == $past(w_en_bit)) && (pend_dly == $past(w_dly)));
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq #(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY_A = 32'hABCD1234,
   parameter logic [DATA_W-1:0] KEY_B = 32'h4321DCBA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic [DATA_W-1:0] wdata,
   input  logic              flush,
   output logic              svc_ok,
   output logic              bad
);
   logic armed;
   logic key_a_hit;
   logic key_b_hit;

   assign key_a_hit = (wdata == KEY_A);
   assign key_b_hit = (wdata == KEY_B);

   always_comb begin
      svc_ok = 1'b0;
      bad    = 1'b0;
      if (armed) begin
         svc_ok = wr_b && key_b_hit;
         bad    = wr_a || (wr_b && !key_b_hit);
      end else begin
         bad    = wr_b || (wr_a && !key_a_hit);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 armed <= 1'b0;
      else if (flush)             armed <= 1'b0;
      else if (armed)             armed <= !(wr_a || wr_b);
      else if (wr_a && key_a_hit) armed <= 1'b1;
   end

   // R5
   bad_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(bad) |-> !armed);

   // R2
   svc_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(svc_ok) |-> !armed);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic             flush,
   input  logic             pend_en,
   input  logic [DLY_W-1:0] pend_dly,
   output logic             timeout
);
   localparam int             CNT_W = (1 << DLY_W) + 1;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [DLY_W:0]   SH1 = {{DLY_W{1'b0}}, 1'b1};

   logic             act_en;
   logic [DLY_W-1:0] act_dly;
   logic [CNT_W-1:0] cnt;
   logic [DLY_W:0]   shamt;
   logic [CNT_W-1:0] last_val;

   assign shamt    = {1'b0, act_dly} + SH1;
   assign last_val = (ONE << shamt) - ONE;
   assign timeout  = act_en && tick && (cnt == last_val) && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en  <= 1'b0;
         act_dly <= '0;
         cnt     <= '0;
      end else if (flush) begin
         act_en  <= 1'b0;
         act_dly <= '0;
         cnt     <= '0;
      end else if (reload) begin
         act_en  <= pend_en;
         act_dly <= pend_dly;
         cnt     <= '0;
      end else if (act_en && tick) begin
         cnt     <= cnt + ONE;
      end
   end

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_val);

   // R2
   reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(reload) |-> (cnt == '0));
endmodule

// File: rtl/kwd_cause.sv
module kwd_cause
   import kwd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       user_rst,
   input  logic       soft_hit,
   input  logic       bad,
   input  logic       timeout,
   output logic       flush,
   output logic       rst_req,
   output logic [2:0] cause
);
   cause_e nxt;
   cause_e code_q;

   assign flush = user_rst || soft_hit || bad || timeout;

   always_comb begin
      if (user_rst)      nxt = CAUSE_USER;
      else if (soft_hit) nxt = CAUSE_SOFT;
      else if (bad)      nxt = CAUSE_BAD;
      else if (timeout)  nxt = CAUSE_TMO;
      else               nxt = code_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         code_q  <= CAUSE_HARD;
      end else begin
         rst_req <= flush;
         code_q  <= nxt;
      end
   end

   assign cause = code_q;

   // R10
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != $past(cause)) |-> rst_req);

   // R9
   req_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cause != 3'(CAUSE_HARD)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 4,
   parameter int                DLY_W     = 5,
   parameter int                EN_BIT    = 31,
   parameter logic [DATA_W-1:0] KEY_A     = 32'hABCD1234,
   parameter logic [DATA_W-1:0] KEY_B     = 32'h4321DCBA,
   parameter bit                READ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              user_rst,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_req
);
   generate
      if (ADDR_W < 4) begin : g_chk_addr
         $error("ADDR_W must cover four word registers");
      end
      if (DLY_W < 1 || DLY_W > 6) begin : g_chk_dly
         $error("DLY_W out of supported range");
      end
      if (EN_BIT >= DATA_W || EN_BIT < DLY_W) begin : g_chk_en
         $error("EN_BIT must lie above the delay field and inside the word");
      end
      if (DATA_W < 8) begin : g_chk_data
         $error("DATA_W too narrow");
      end
   endgenerate

   logic             wr_svc_a;
   logic             wr_svc_b;
   logic             soft_hit;
   logic             pend_en;
   logic [DLY_W-1:0] pend_dly;
   logic             svc_ok;
   logic             bad;
   logic             timeout;
   logic             flush;
   logic [2:0]       cause;

   kwd_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W),
      .EN_BIT(EN_BIT), .READ_FLOP(READ_FLOP)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .w_en_bit  (wdata[EN_BIT]),
      .w_dly     (wdata[DLY_W-1:0]),
      .w_soft_bit(wdata[0]),
      .flush     (flush),
      .cause     (cause),
      .wr_svc_a  (wr_svc_a),
      .wr_svc_b  (wr_svc_b),
      .soft_hit  (soft_hit),
      .pend_en   (pend_en),
      .pend_dly  (pend_dly),
      .rdata     (rdata)
   );

   kwd_keyseq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keyseq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_a  (wr_svc_a),
      .wr_b  (wr_svc_b),
      .wdata (wdata),
      .flush (flush),
      .svc_ok(svc_ok),
      .bad   (bad)
   );

   kwd_counter #(.DLY_W(DLY_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en),
      .reload  (svc_ok),
      .flush   (flush),
      .pend_en (pend_en),
      .pend_dly(pend_dly),
      .timeout (timeout)
   );

   kwd_cause u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .user_rst(user_rst),
      .soft_hit(soft_hit),
      .bad     (bad),
      .timeout (timeout),
      .flush   (flush),
      .rst_req (rst_req),
      .cause   (cause)
   );
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   localparam logic [31:0] KA = 32'hABCD1234;
   localparam logic [31:0] KB = 32'h4321DCBA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        user_rst = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req;
   logic        req_seen;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   keyed_watchdog uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .user_rst(user_rst),
      .rdata(rdata), .rst_req(rst_req)
   );

   function automatic int period(int d);
      return 1 << (d + 1);
   endfunction

   function automatic logic [31:0] cfg_word(bit en, int d);
      return {en, 26'd0, d[4:0]};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      req_seen = rst_req;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic service();
      wr(4'h8, KA);
      wr(4'hC, KB);
   endtask

   task automatic ticks(int n, output int hit);
      hit = 0;
      for (int i = 1; i <= n; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
         if (rst_req && hit == 0) hit = i;
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] w;
      logic [31:0] badv;
      int h;
      int d;
      int kind;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 / R10 reset state
      rd(4'h4, v); chk("R11 cfg after reset", v, 0);
      rd(4'h8, v); chk("R10 cause after reset", v, 0);
      chk("R11 no request after reset", rst_req, 0);
      ticks(10, h); chk("R11 idle ticks", h, 0);

      // R1 readback and decode
      for (int k = 0; k < 4; k++) begin
         w = $urandom;
         wr(4'h4, w); rd(4'h4, v);
         chk("R1 cfg readback", v, w & 32'h8000001F);
      end
      rd(4'h0, v); chk("R1 soft reg reads zero", v, 0);
      rd(4'hC, v); chk("R1 service B reads zero", v, 0);
      rd(4'h5, v); chk("R1 unaligned reads zero", v, 0);

      // R4 enable without service does not start counting
      wr(4'h4, cfg_word(1, 0));
      ticks(12, h); chk("R4 no count before service", h, 0);

      // R2 / R3 / R9 random delays
      for (int k = 0; k < 5; k++) begin
         d = $urandom % 5;
         wr(4'h4, cfg_word(1, d));
         service(); chk("R2 service raises nothing", req_seen, 0);
         ticks(period(d) + 2, h); chk("R3 timeout tick index", h, period(d));
         rd(4'h8, v); chk("R3 cause timeout", v, 1);
         rd(4'h4, v); chk("R9 pending cleared", v, 0);
         ticks(period(d) + 3, h); chk("R9 inactive after request", h, 0);
      end

      // R2 service reloads the count
      wr(4'h4, cfg_word(1, 2)); service();
      ticks(6, h); chk("R2 before reload", h, 0);
      service();
      ticks(7, h); chk("R2 reload restarts period", h, 0);
      ticks(1, h); chk("R3 last tick after reload", h, 1);

      // R4 clearing enable without service keeps counting
      wr(4'h4, cfg_word(1, 1)); service();
      wr(4'h4, cfg_word(0, 1));
      ticks(5, h); chk("R4 disable pending still times out", h, 4);
      wr(4'h4, cfg_word(1, 1)); service();
      wr(4'h4, cfg_word(0, 1)); service();
      ticks(10, h); chk("R4 disable after service stops", h, 0);

      // R5 bad tickle shapes
      for (int k = 0; k < 8; k++) begin
         kind = $urandom % 4;
         badv = $urandom;
         if (badv == KA || badv == KB) badv = badv ^ 32'h1;
         case (kind)
            0: wr(4'h8, badv);
            1: wr(4'hC, (k % 2) ? KB : badv);
            2: begin
               wr(4'h8, KA); chk("R5 first key alone ok", req_seen, 0);
               wr(4'hC, badv);
            end
            default: begin
               wr(4'h8, KA);
               wr(4'h8, KA);
            end
         endcase
         chk("R5 bad tickle request", req_seen, 1);
         rd(4'h8, v); chk("R5 cause bad tickle", v, 2);
      end

      // R2 config write between keys keeps the sequence
      wr(4'h4, cfg_word(1, 3)); wr(4'h8, KA); wr(4'h4, cfg_word(1, 0));
      wr(4'hC, KB); chk("R2 sequence across cfg write", req_seen, 0);
      ticks(period(0), h); chk("R3 latest pending delay used", h, 2);

      // R6 soft reset
      wr(4'h0, 32'hFFFF_FFFE); chk("R6 bit0 clear no request", req_seen, 0);
      rd(4'h8, v); chk("R6 cause unchanged", v, 1);
      wr(4'h0, 32'h1); chk("R6 soft request", req_seen, 1);
      @(negedge clk); chk("R9 request one cycle", rst_req, 0);
      rd(4'h8, v); chk("R6 cause soft", v, 3);

      // R7 user reset
      @(negedge clk) user_rst = 1'b1;
      @(negedge clk) user_rst = 1'b0;
      chk("R7 user request", rst_req, 1);
      rd(4'h8, v); chk("R7 cause user", v, 4);

      // R8 priority: timeout and bad tickle together
      wr(4'h4, cfg_word(1, 0)); service();
      ticks(1, h);
      @(negedge clk);
      tick_en = 1'b1; addr = 4'hC; wdata = 32'h0; wr_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0;
      chk("R8 coincident request", rst_req, 1);
      rd(4'h8, v); chk("R8 bad over timeout", v, 2);

      // R8 user with soft reset together
      @(negedge clk);
      user_rst = 1'b1; addr = 4'h0; wdata = 32'h1; wr_en = 1'b1;
      @(negedge clk);
      user_rst = 1'b0; wr_en = 1'b0;
      rd(4'h8, v); chk("R8 user over soft", v, 4);

      // R9 half-done sequence abandoned by a request
      wr(4'h8, KA);
      @(negedge clk) user_rst = 1'b1;
      @(negedge clk) user_rst = 1'b0;
      wr(4'hC, KB); chk("R9 sequence abandoned", req_seen, 1);
      rd(4'h8, v); chk("R9 second key alone is bad", v, 2);

      // R10 hard reset clears the cause
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk); chk("R10 no request in reset", rst_req, 0);
      rst_n = 1'b1;
      rd(4'h8, v); chk("R10 cause cleared", v, 0);

      summary();
   end
endmodule